// File: doc/BRIEF.md
# Programmable Multi-Phase Pulse Timing Generator

This block produces fourteen timing pulses for an optical measurement front end. Every pulse is defined against one shared period counter that counts clock cycles of the timebase. The pulses are an on window for each of two light sources, three sample windows around them, four converter windows and four converter-reset pulses. Each pulse has a programmable first and last count. The last count is inclusive. The counter's terminal count is also programmable. A plain register write port loads the 29 timing values, and a combinational read port returns them.

The block accepts any programmed values without clamping or checking. Software is responsible for keeping windows apart and for keeping edges within the period. A typical setup uses a terminal count of 7999, which gives 8000 cycles per period, or 500 Hz from a 4 MHz timebase. In that setup the converter windows run in the order source-2, source-2 ambient, source-1, source-1 ambient. The sample windows lead them by one phase. Each converter window starts one cycle after its reset pulse ends.

The counter is driven by a two-state machine. HALT holds the count at 0. COUNT advances the count. Transition START (HALT to COUNT) occurs when the enable input is high at a clock edge. STOP (COUNT to HALT) occurs when enable is low. Inside COUNT there are two events: STEP adds one to the count, and WRAP returns the count to 0.

Top module: `pulse_timing_gen`

## Requirements
- R1: Register addresses 1 to 28 hold the pulse windows. Address 2k+1 is the first count of pulse k, and address 2k+2 is its last count, for k = 0..13. Address 29 holds the terminal count. Pulse k drives bit k of `pulse_out`, with bits in this order: source-2 sample, source-2 on, source-2 ambient sample, source-1 sample, source-1 on, source-1 ambient sample, convert source-2, convert source-2 ambient, convert source-1, convert source-1 ambient, reset 0, reset 1, reset 2, reset 3.
- R2: `rd_data` combinationally returns the 16-bit value stored at `rd_addr`. Addresses 0, 30 and 31 always read 0, and writes to them change nothing.
- R3: While enabled, the count starts at 0 and adds one per cycle (STEP). The cycle after the count is at or above the terminal count, it returns to 0 (WRAP). A terminal count of P therefore gives a period of P+1 cycles.
- R4: Bit k of `pulse_out` is high in the cycle that follows a cycle whose count c satisfies first ≤ c ≤ last. This gives one cycle of latency.
- R5: A window whose first count equals its last count is high for exactly one cycle per period.
- R6: A window whose first count is greater than its last count never goes high. A last count beyond the terminal count is not clamped; the window simply ends at the wrap.
- R7: `period_start` is high for one cycle per period, in the cycle that follows count 0.
- R8: A write takes effect at the clock edge that captures it. If a new terminal count is below the current count, the next cycle is a WRAP.
- R9: While `en` is low, `pulse_out` and `period_start` are 0 at once and the count is held at 0 (HALT). After `en` returns high, counting restarts from 0.
- R10: Synchronous reset `rst` clears the count, all 29 registers and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | timebase clock |
| rst | input | 1 | synchronous reset, active high |
| en | input | 1 | run enable; low holds the count at 0 and forces outputs low |
| wr_en | input | 1 | write strobe |
| wr_addr | input | 5 | write register address |
| wr_data | input | 16 | write data |
| rd_addr | input | 5 | read register address |
| rd_data | output | 16 | read data (combinational) |
| pulse_out | output | 14 | pulse outputs, bit order per R1 |
| period_start | output | 1 | one-cycle strobe after count 0 |

## Verification
The pulse bits and `period_start` are registered from the count, so each one appears one cycle after the count it reflects. The count itself steps at every edge. A write updates a register at its capturing edge, but the comparison made at that same edge still uses the old value. The bench keeps a cycle-accurate reference of the count and the registers, updated at each rising edge from the requirements. It compares all fifteen output bits 1 ns after every rising edge. The gating by `en` and the read port are combinational, so they are checked 1 ns after the input changes, with no clock edge in between.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int CNT_W      = 16;
    localparam int NUM_PULSES = 14;
    localparam int ADDR_W     = 5;
    localparam int PERIOD_IDX = 2 * NUM_PULSES + 1;

    typedef struct packed {
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] last;
    } window_t;
endpackage

// File: rtl/ptg_regfile.sv
module ptg_regfile
    import ptg_pkg::*;
#(
    parameter int N  = NUM_PULSES,
    parameter int AW = ADDR_W,
    parameter int W  = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output window_t       win [N],
    output logic [W-1:0]  period
);
    localparam int PER_ADDR = 2 * N + 1;

    // one first/last pair per pulse, decoded from its own two addresses
    for (genvar g = 0; g < N; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                win[g] <= '0;
            end else if (wr_en) begin
                if (wr_addr == AW'(2 * g + 1)) win[g].first <= wr_data;
                if (wr_addr == AW'(2 * g + 2)) win[g].last  <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                       period <= '0;
        else if (wr_en && wr_addr == AW'(PER_ADDR))    period <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_addr == AW'(2 * k + 1)) rd_data = win[k].first;
            if (rd_addr == AW'(2 * k + 2)) rd_data = win[k].last;
        end
        if (rd_addr == AW'(PER_ADDR)) rd_data = period;
    end
endmodule

// File: rtl/ptg_period_counter.sv
module ptg_period_counter
    import ptg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         start_strobe
);
    typedef enum logic [0:0] {ST_HALT, ST_COUNT} state_t;

    state_t       state, state_nxt;
    logic [W-1:0] cnt_nxt, cnt_step;

    // WRAP on reaching or passing the terminal count, otherwise STEP
    assign cnt_step = (cnt >= period) ? '0 : cnt + W'(1);

    always_comb begin
        state_nxt = state;
        cnt_nxt   = '0;
        unique case (state)
            ST_HALT: begin
                if (en) begin
                    state_nxt = ST_COUNT;      // START
                    cnt_nxt   = cnt_step;
                end
            end
            ST_COUNT: begin
                if (!en) begin
                    state_nxt = ST_HALT;       // STOP
                end else begin
                    cnt_nxt   = cnt_step;      // STEP or WRAP
                end
            end
            default: state_nxt = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HALT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) start_strobe <= 1'b0;
        else     start_strobe <= en && (cnt == '0);
    end
endmodule

// File: rtl/ptg_window.sv
module ptg_window
    import ptg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  window_t      win,
    output logic         pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= en && (cnt >= win.first) && (cnt <= win.last);
    end
endmodule

// File: rtl/pulse_timing_gen.sv
module pulse_timing_gen
    import ptg_pkg::*;
#(
    parameter int N  = NUM_PULSES,
    parameter int AW = ADDR_W,
    parameter int W  = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic [N-1:0]  pulse_out,
    output logic          period_start
);
    window_t      win [N];
    logic [W-1:0] period_val;
    logic [W-1:0] cnt;
    logic         strobe_q;
    logic [N-1:0] pulse_q;

    ptg_regfile #(.N(N), .AW(AW), .W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .win     (win),
        .period  (period_val)
    );

    ptg_period_counter #(.W(W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .period       (period_val),
        .cnt          (cnt),
        .start_strobe (strobe_q)
    );

    for (genvar g = 0; g < N; g++) begin : g_win
        ptg_window #(.W(W)) u_win (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .cnt   (cnt),
            .win   (win[g]),
            .pulse (pulse_q[g])
        );
    end

    assign pulse_out    = pulse_q & {N{en}};
    assign period_start = strobe_q & en;
endmodule

// File: rtl/pulse_timing_gen_chk.sv
module pulse_timing_gen_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] cnt,
    input logic [W-1:0] period,
    input logic         period_start
);
    // R3: counting below the terminal count advances by one
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (en && cnt < period) |=> (cnt == $past(cnt) + W'(1)));

    // R3 / R8: at or above the terminal count the next count is 0
    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && cnt >= period) |=> (cnt == '0));

    // R9: disabling holds the count at 0
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

    // R9: counting resumes from 0
    a_r9_resume: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (cnt == '0));

    // R7: the strobe only follows a cycle at count 0
    a_r7_strobe: assert property (@(posedge clk) disable iff (rst)
        period_start |-> ($past(cnt) == '0));
endmodule

bind pulse_timing_gen pulse_timing_gen_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .cnt          (cnt),
    .period       (period_val),
    .period_start (period_start)
);

// File: tb/pulse_timing_gen_test.sv
`timescale 1ns/100ps
module pulse_timing_gen_test;
    localparam int N  = 14;
    localparam int AW = 5;
    localparam int W  = 16;
    localparam int NV = 29;

    // {address, data}: window programming, then terminal count 39
    localparam logic [AW+W-1:0] VEC [NV] = '{
        {5'd1, 16'd30}, {5'd2, 16'd38},  {5'd3, 16'd29}, {5'd4, 16'd39},
        {5'd5, 16'd2},  {5'd6, 16'd8},   {5'd7, 16'd12}, {5'd8, 16'd18},
        {5'd9, 16'd10}, {5'd10, 16'd19}, {5'd11, 16'd22}, {5'd12, 16'd28},
        {5'd13, 16'd1}, {5'd14, 16'd9},  {5'd15, 16'd11}, {5'd16, 16'd19},
        {5'd17, 16'd21}, {5'd18, 16'd29}, {5'd19, 16'd31}, {5'd20, 16'd39},
        {5'd21, 16'd0}, {5'd22, 16'd0},  {5'd23, 16'd10}, {5'd24, 16'd10},
        {5'd25, 16'd25}, {5'd26, 16'd20}, {5'd27, 16'd35}, {5'd28, 16'd60},
        {5'd29, 16'd39}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic [N-1:0]  pulse_out;
    logic          period_start;

    int checks = 0;
    int errors = 0;
    logic  cmp_on = 1'b0;
    string cur_tag = "R3/R4/R7";

    always #2 clk = ~clk;

    pulse_timing_gen uut (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pulse_out(pulse_out), .period_start(period_start)
    );

    // reference built from the requirements
    logic [W-1:0] m_reg [32];
    logic [W-1:0] m_cnt;
    logic [N-1:0] m_q;
    logic         m_ps;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) m_reg[i] <= '0;
            m_cnt <= '0; m_q <= '0; m_ps <= 1'b0;
        end else begin
            if (wr_en && wr_addr >= 1 && wr_addr <= 29) m_reg[wr_addr] <= wr_data;
            if (!en) begin
                m_cnt <= '0; m_q <= '0; m_ps <= 1'b0;
            end else begin
                m_cnt <= (m_cnt >= m_reg[29]) ? '0 : m_cnt + 16'd1;
                m_ps  <= (m_cnt == '0);
                for (int k = 0; k < N; k++)
                    m_q[k] <= (m_cnt >= m_reg[2*k+1]) && (m_cnt <= m_reg[2*k+2]);
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            logic [N:0] exp_v, act_v;
            exp_v = {m_ps & en, m_q & {N{en}}};
            act_v = {period_start, pulse_out};
            check(act_v == exp_v, cur_tag, int'(act_v), int'(exp_v));
        end
    end

    task automatic write_reg(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == exp, tag, int'(rd_data), int'(exp));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c10, c12, c13, cps;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(pulse_out == '0 && period_start == 1'b0, "R10 reset outputs",
              int'({period_start, pulse_out}), 0);
        read_chk(5'd29, 16'd0, "R10 reset register");

        // R1: program the map from the vector table, then read it back
        for (int i = 0; i < NV; i++) write_reg(VEC[i][AW+W-1:W], VEC[i][W-1:0]);
        for (int i = 0; i < NV; i++) read_chk(VEC[i][AW+W-1:W], VEC[i][W-1:0], "R1 readback");

        // R2: unmapped addresses
        write_reg(5'd0, 16'h1234);
        write_reg(5'd30, 16'h5678);
        write_reg(5'd31, 16'h9abc);
        read_chk(5'd0, 16'd0, "R2 unmapped 0");
        read_chk(5'd30, 16'd0, "R2 unmapped 30");
        read_chk(5'd31, 16'd0, "R2 unmapped 31");
        read_chk(5'd1, 16'd30, "R2 neighbour untouched");
        read_chk(5'd29, 16'd39, "R2 period untouched");

        // R3 / R4 / R7: free run against the reference
        @(negedge clk);
        cmp_on = 1'b1;
        en = 1'b1;
        repeat (90) @(negedge clk);

        // R5 / R6 / R7: one full period of 40 cycles
        c10 = 0; c12 = 0; c13 = 0; cps = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            c10 += pulse_out[10]; c12 += pulse_out[12];
            c13 += pulse_out[13]; cps += period_start;
        end
        check(c10 == 1, "R5 equal first/last width", c10, 1);
        check(c12 == 0, "R6 inverted window", c12, 0);
        check(c13 == 5, "R6 last beyond period", c13, 5);
        check(cps == 1, "R7 strobe per period", cps, 1);

        // R8: shrink the terminal count below the running count
        cur_tag = "R8 shrink";
        @(posedge period_start);
        repeat (20) @(negedge clk);
        write_reg(5'd29, 16'd5);
        @(posedge clk); @(posedge clk); #1;
        check(period_start == 1'b1, "R8 forced wrap", int'(period_start), 1);
        cps = 0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1;
            cps += period_start;
        end
        check(cps == 2, "R8 new period of 6", cps, 2);
        write_reg(5'd29, 16'd39);
        repeat (30) @(negedge clk);

        // R9: disable mid-run
        cur_tag = "R9 enable";
        @(negedge clk);
        en = 1'b0;
        #1;
        check(pulse_out == '0 && period_start == 1'b0, "R9 immediate low",
              int'({period_start, pulse_out}), 0);
        repeat (10) @(negedge clk);
        en = 1'b1;
        repeat (60) @(negedge clk);

        // R10: reset mid-run
        cur_tag = "R10 reset";
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(pulse_out == '0 && period_start == 1'b0, "R10 outputs cleared",
              int'({period_start, pulse_out}), 0);
        for (int i = 0; i < NV; i++) read_chk(VEC[i][AW+W-1:W], 16'd0, "R10 registers cleared");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        cmp_on = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule